// File: doc/BRIEF.md
# Block Cipher Host Register Controller

This block is the register-mapped front end that sits between a 32-bit host register bus and a 64-bit block cipher core. It holds the cipher context: three 64-bit keys, a 64-bit initialisation vector and a control word that selects the chaining mode, single- or triple-key operation and the direction. It also holds a byte-length counter and a 64-bit data window that is read and written as two 32-bit halves. The rounds of the cipher are not part of this block. They live in a core that receives a one-cycle start pulse and answers with a done pulse carrying the result block.

Writing a non-zero byte count to the length register locks the context and opens the input side. Each write of the upper data half while the engine is ready for input hands one block to the core. Each read of the upper result half while a result is pending releases that block and takes eight bytes off the count, saturating at zero. When the count reaches zero the context unlocks for the next job. Three ready flags (context, input, output) gate these transfers. The same flags feed an interrupt status register with write-one-to-clear bits and a per-bit enable, and they drive three DMA request levels that the host can switch on individually.

Top module: `cipher_hostregs`

## Requirements
- R1: After reset the control word (byte offset 0x20) reads 0x8000_0000: bit 31 (context ready) is 1, bits 1 (input ready) and 0 (output ready) are 0, and mode, key-count and direction are 0. `irq` and all three DMA requests are 0.
- R2: A control write while the context is open sets mode from bits [5:4] (0 ECB, 1 CBC, 2 CFB), triple-key from bit 3 and encrypt from bit 2, and these bits read back and drive `core_mode`, `core_triple` and `core_encrypt`. A write with bits [5:4] = 3 leaves the previous mode in place but still updates bits 3 and 2.
- R3: While control bit 31 reads 0, writes to the key, IV and control registers have no effect on the core-facing outputs.
- R4: Writing a non-zero value to the length register (0x24) while bit 31 is 1 clears bit 31 and sets bit 1. Writing 0 starts nothing. Reads of 0x24 always return 0.
- R5: Writing the upper data half (0x2C) while bit 1 is 1 clears bit 1 and raises `core_start` for exactly one cycle, with `core_din` = {upper half, last lower half written to 0x28}. A write to 0x2C while bit 1 is 0 produces no start.
- R6: A `core_done` pulse while a block is in flight captures `core_dout` and sets bit 0. Reads of 0x28 and 0x2C then return the result's lower and upper 32 bits.
- R7: Reading 0x2C while bit 0 is 1 clears bit 0 and lowers the remaining count by 8, saturating at 0. If bytes remain, bit 1 returns to 1. Otherwise bit 31 returns to 1, so a count of L bytes takes ceil(L/8) blocks.
- R8: Interrupt status (0x3C) bit 2 is set by an accepted `core_done`, bit 1 each time input ready rises, and bit 0 when the context reopens. Writing 1 to a status bit clears it.
- R9: `irq` is 1 exactly when some status bit and the enable bit at the same position (0x40, bits [2:0]) are both 1.
- R10: DMA configuration bits 7, 6 and 5 at 0x34 gate `dma_ctx_req`, `dma_out_req` and `dma_in_req`, which follow context ready, output ready and input ready respectively.
- R11: The key and IV words are mapped as key3 {0x04,0x00}, key2 {0x0C,0x08}, key1 {0x14,0x10}, IV {0x1C,0x18} (upper, lower). They appear on `core_key` (key1 in bits [63:0], key2 in [127:64], key3 in [191:128]) and `core_iv`, and host reads of these words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects apply at the clock edge |
| reg_addr | input | 7 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |
| core_start | output | 1 | One-cycle pulse handing a block to the core |
| core_mode | output | 2 | Chaining mode |
| core_triple | output | 1 | Triple-key operation |
| core_encrypt | output | 1 | 1 encrypt, 0 decrypt |
| core_key | output | 192 | Keys 1, 2, 3 from low to high |
| core_iv | output | 64 | Initialisation vector |
| core_din | output | 64 | Input block |
| core_done | input | 1 | Result-valid pulse from the core |
| core_dout | input | 64 | Result block |
| irq | output | 1 | Masked interrupt |
| dma_ctx_req | output | 1 | DMA request for the next context |
| dma_in_req | output | 1 | DMA request for an input block |
| dma_out_req | output | 1 | DMA request for a result block |

## Verification
The hardest situation to reach is the last block of a job whose byte count is not a multiple of eight. Here the saturating decrement must end the job and reopen the context instead of asking for one more block. The interrupt and DMA lines must also switch over on that same release. The bench drives whole jobs through the register bus with a latency-delayed stub core. It uses directed counts such as 20, which leaves a 4-byte tail, together with random counts from 1 to 40 and random modes and data. In every job it checks that exactly ceil(L/8) results come back before bit 31 returns, and it also tries writes to the locked context, writes of the reserved mode and upper-half writes made while input is closed.

// File: rtl/cipher_regs_pkg.sv
package cipher_regs_pkg;

    localparam int WORD_W    = 32;
    localparam int BLK_W     = 2 * WORD_W;
    localparam int ADDR_W    = 7;
    localparam int NUM_KEYS  = 3;
    localparam int CTX_WORDS = 2 * NUM_KEYS + 2;
    localparam int NUM_EVT   = 3;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] ADR_CTRL     = 7'h20;
    localparam logic [ADDR_W-1:0] ADR_LEN      = 7'h24;
    localparam logic [ADDR_W-1:0] ADR_DATA_L   = 7'h28;
    localparam logic [ADDR_W-1:0] ADR_DATA_H   = 7'h2C;
    localparam logic [ADDR_W-1:0] ADR_SYSCFG   = 7'h34;
    localparam logic [ADDR_W-1:0] ADR_IRQ_STAT = 7'h3C;
    localparam logic [ADDR_W-1:0] ADR_IRQ_EN   = 7'h40;

    typedef enum logic [1:0] {
        CHAIN_ECB  = 2'd0,
        CHAIN_CBC  = 2'd1,
        CHAIN_CFB  = 2'd2,
        CHAIN_RSVD = 2'd3
    } chain_e;

    typedef struct packed {
        chain_e mode;
        logic   triple;
        logic   encrypt;
    } ctrl_t;

    // Bit order matches the interrupt status layout: [2] out, [1] in, [0] ctx
    typedef struct packed {
        logic out_rdy;
        logic in_rdy;
        logic ctx_rdy;
    } rdy_t;

    function automatic logic [WORD_W-1:0] sat_dec(input logic [WORD_W-1:0] v,
                                                  input int step);
        if (v > WORD_W'(step)) return v - WORD_W'(step);
        return '0;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(input rdy_t r, input ctrl_t c);
        logic [WORD_W-1:0] w;
        w      = '0;
        w[31]  = r.ctx_rdy;
        w[5:4] = c.mode;
        w[3]   = c.triple;
        w[2]   = c.encrypt;
        w[1]   = r.in_rdy;
        w[0]   = r.out_rdy;
        return w;
    endfunction

endpackage

// File: rtl/cipher_ctx_store.sv
module cipher_ctx_store
    import cipher_regs_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [WORD_W-1:0]          wdata,
    input  logic                       ctx_open,
    output logic [NUM_KEYS*BLK_W-1:0]  keys,
    output logic [BLK_W-1:0]           iv,
    output ctrl_t                      ctrl
);

    logic [WORD_W-1:0] word_q [CTX_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < CTX_WORDS; w++) word_q[w] <= '0;
        end else if (wr_en && ctx_open) begin
            for (int w = 0; w < CTX_WORDS; w++) begin
                if (addr == ADDR_W'(4 * w)) word_q[w] <= wdata;
            end
        end
    end

    // Key k (k = 0 is key1) sits in the word pair counted down from the top key
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        localparam int BASE = 2 * (NUM_KEYS - 1 - k);
        assign keys[k*BLK_W +: BLK_W] = {word_q[BASE+1], word_q[BASE]};
    end

    assign iv = {word_q[CTX_WORDS-1], word_q[CTX_WORDS-2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{mode: CHAIN_ECB, triple: 1'b0, encrypt: 1'b0};
        end else if (wr_en && ctx_open && addr == ADR_CTRL) begin
            ctrl.triple  <= wdata[3];
            ctrl.encrypt <= wdata[2];
            if (wdata[5:4] != CHAIN_RSVD) ctrl.mode <= chain_e'(wdata[5:4]);
        end
    end

endmodule

// File: rtl/cipher_flow_ctrl.sv
module cipher_flow_ctrl
    import cipher_regs_pkg::*;
#(
    parameter int BLOCK_BYTES = BLK_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              len_wr,
    input  logic [WORD_W-1:0] len_val,
    input  logic              hi_wr,
    input  logic              hi_rd,
    input  logic              core_done,
    output rdy_t              rdy,
    output logic              core_start,
    output logic              res_load,
    output rdy_t              evt
);

    logic [WORD_W-1:0] len_q;
    logic [WORD_W-1:0] len_nxt;
    logic              in_flight;
    logic              launch;
    logic              accept;
    logic              release_blk;
    logic              last_blk;

    assign in_flight   = !rdy.ctx_rdy && !rdy.in_rdy && !rdy.out_rdy;
    assign launch      = len_wr && rdy.ctx_rdy && (len_val != '0);
    assign accept      = hi_wr && rdy.in_rdy;
    assign release_blk = hi_rd && rdy.out_rdy;
    assign res_load    = core_done && in_flight;
    assign len_nxt     = sat_dec(len_q, BLOCK_BYTES);
    assign last_blk    = release_blk && (len_nxt == '0);

    always_comb begin
        evt.ctx_rdy = last_blk;
        evt.in_rdy  = launch || (release_blk && !last_blk);
        evt.out_rdy = res_load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy        <= '{out_rdy: 1'b0, in_rdy: 1'b0, ctx_rdy: 1'b1};
            len_q      <= '0;
            core_start <= 1'b0;
        end else begin
            core_start <= 1'b0;
            if (launch) begin
                len_q       <= len_val;
                rdy.ctx_rdy <= 1'b0;
                rdy.in_rdy  <= 1'b1;
            end
            if (accept) begin
                rdy.in_rdy <= 1'b0;
                core_start <= 1'b1;
            end
            if (res_load) begin
                rdy.out_rdy <= 1'b1;
            end
            if (release_blk) begin
                rdy.out_rdy <= 1'b0;
                len_q       <= len_nxt;
                if (last_blk) rdy.ctx_rdy <= 1'b1;
                else          rdy.in_rdy  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cipher_irq_unit.sv
module cipher_irq_unit
    import cipher_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               clr_wr,
    input  logic               en_wr,
    input  logic [NUM_EVT-1:0] wbits,
    output logic [NUM_EVT-1:0] stat,
    output logic [NUM_EVT-1:0] en,
    output logic               irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
        end else begin
            for (int i = 0; i < NUM_EVT; i++) begin
                // a new event outranks a clear in the same cycle
                stat[i] <= evt[i] | (stat[i] & ~(clr_wr & wbits[i]));
            end
            if (en_wr) en <= wbits;
        end
    end

    assign irq = |(stat & en);

endmodule

// File: rtl/cipher_hostregs.sv
module cipher_hostregs
    import cipher_regs_pkg::*;
#(
    parameter int BLOCK_BYTES = BLK_W / 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [WORD_W-1:0]         reg_wdata,
    output logic [WORD_W-1:0]         reg_rdata,
    output logic                      core_start,
    output logic [1:0]                core_mode,
    output logic                      core_triple,
    output logic                      core_encrypt,
    output logic [NUM_KEYS*BLK_W-1:0] core_key,
    output logic [BLK_W-1:0]          core_iv,
    output logic [BLK_W-1:0]          core_din,
    input  logic                      core_done,
    input  logic [BLK_W-1:0]          core_dout,
    output logic                      irq,
    output logic                      dma_ctx_req,
    output logic                      dma_in_req,
    output logic                      dma_out_req
);

    localparam int SYSC_LO = 5;

    rdy_t                rdy;
    rdy_t                evt;
    ctrl_t               ctrl;
    logic                res_load;
    logic [NUM_EVT-1:0]  irq_stat;
    logic [NUM_EVT-1:0]  irq_en;
    logic [WORD_W-1:0]   din_lo_q;
    logic [WORD_W-1:0]   din_hi_q;
    logic [BLK_W-1:0]    dout_q;
    logic [NUM_EVT-1:0]  sysc_q;
    logic                wr_len, wr_lo, wr_hi, rd_hi;

    assign wr_len = reg_wr && reg_addr == ADR_LEN;
    assign wr_lo  = reg_wr && reg_addr == ADR_DATA_L;
    assign wr_hi  = reg_wr && reg_addr == ADR_DATA_H;
    assign rd_hi  = reg_rd && reg_addr == ADR_DATA_H;

    cipher_ctx_store u_ctx (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ctx_open (rdy.ctx_rdy),
        .keys     (core_key),
        .iv       (core_iv),
        .ctrl     (ctrl)
    );

    cipher_flow_ctrl #(.BLOCK_BYTES(BLOCK_BYTES)) u_flow (
        .clk        (clk),
        .rst        (rst),
        .len_wr     (wr_len),
        .len_val    (reg_wdata),
        .hi_wr      (wr_hi),
        .hi_rd      (rd_hi),
        .core_done  (core_done),
        .rdy        (rdy),
        .core_start (core_start),
        .res_load   (res_load),
        .evt        (evt)
    );

    cipher_irq_unit u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .clr_wr (reg_wr && reg_addr == ADR_IRQ_STAT),
        .en_wr  (reg_wr && reg_addr == ADR_IRQ_EN),
        .wbits  (reg_wdata[NUM_EVT-1:0]),
        .stat   (irq_stat),
        .en     (irq_en),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            din_lo_q <= '0;
            din_hi_q <= '0;
            dout_q   <= '0;
            sysc_q   <= '0;
        end else begin
            if (wr_lo) din_lo_q <= reg_wdata;
            if (wr_hi && rdy.in_rdy) din_hi_q <= reg_wdata;
            if (res_load) dout_q <= core_dout;
            if (reg_wr && reg_addr == ADR_SYSCFG)
                sysc_q <= reg_wdata[SYSC_LO +: NUM_EVT];
        end
    end

    assign core_din     = {din_hi_q, din_lo_q};
    assign core_mode    = ctrl.mode;
    assign core_triple  = ctrl.triple;
    assign core_encrypt = ctrl.encrypt;

    // sysconfig [7] ctx, [6] out, [5] in
    assign dma_ctx_req = sysc_q[2] & rdy.ctx_rdy;
    assign dma_out_req = sysc_q[1] & rdy.out_rdy;
    assign dma_in_req  = sysc_q[0] & rdy.in_rdy;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                ADR_CTRL:     reg_rdata = pack_ctrl(rdy, ctrl);
                ADR_DATA_L:   reg_rdata = dout_q[WORD_W-1:0];
                ADR_DATA_H:   reg_rdata = dout_q[BLK_W-1:WORD_W];
                ADR_SYSCFG:   reg_rdata = WORD_W'(sysc_q) << SYSC_LO;
                ADR_IRQ_STAT: reg_rdata = WORD_W'(irq_stat);
                ADR_IRQ_EN:   reg_rdata = WORD_W'(irq_en);
                default:      reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cipher_hostregs_chk.sv
module cipher_hostregs_chk
    import cipher_regs_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [WORD_W-1:0]  reg_rdata,
    input logic               core_start,
    input logic               core_done,
    input logic [1:0]         core_mode,
    input logic [2:0]         rdy,
    input logic [2:0]         irq_stat
);

    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rdy));

    // R5
    start_src_chk: assert property (@(posedge clk) disable iff (rst)
        core_start |-> $past(reg_wr && reg_addr == ADR_DATA_H && rdy[1]));

    // R4
    len_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADR_LEN) |-> reg_rdata == '0);

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        core_mode != 2'd3);

    // R6
    out_set_chk: assert property (@(posedge clk) disable iff (rst)
        (core_done && rdy == 3'b000) |=> rdy[2]);

    // R8
    dout_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (core_done && rdy == 3'b000) |=> irq_stat[2]);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADR_DATA_H && rdy[2]) |=> (!rdy[2] && (rdy[0] || rdy[1])));

endmodule

bind cipher_hostregs cipher_hostregs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .core_start (core_start),
    .core_done  (core_done),
    .core_mode  (core_mode),
    .rdy        (rdy),
    .irq_stat   (irq_stat)
);

// File: tb/cipher_hostregs_bench.sv
`timescale 1ns/1ps
module cipher_hostregs_bench;

    localparam int LAT = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [6:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         core_start;
    logic [1:0]   core_mode;
    logic         core_triple;
    logic         core_encrypt;
    logic [191:0] core_key;
    logic [63:0]  core_iv;
    logic [63:0]  core_din;
    logic         core_done;
    logic [63:0]  core_dout;
    logic         irq;
    logic         dma_ctx_req, dma_in_req, dma_out_req;

    int checks = 0;
    int fails  = 0;
    int start_cnt = 0;
    bit reported = 0;

    always #2 clk = ~clk;

    cipher_hostregs u_cipher_hostregs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_start(core_start), .core_mode(core_mode), .core_triple(core_triple),
        .core_encrypt(core_encrypt), .core_key(core_key), .core_iv(core_iv),
        .core_din(core_din), .core_done(core_done), .core_dout(core_dout),
        .irq(irq), .dma_ctx_req(dma_ctx_req), .dma_in_req(dma_in_req),
        .dma_out_req(dma_out_req)
    );

    // stub core: result = din ^ key1 ^ iv after LAT cycles
    int          lat_cnt;
    logic [63:0] stub_din;
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt   <= 0;
            core_done <= 1'b0;
            core_dout <= '0;
            stub_din  <= '0;
        end else begin
            core_done <= 1'b0;
            if (core_start) begin
                lat_cnt  <= LAT;
                stub_din <= core_din;
            end else if (lat_cnt != 0) begin
                lat_cnt <= lat_cnt - 1;
                if (lat_cnt == 1) begin
                    core_done <= 1'b1;
                    core_dout <= stub_din ^ core_key[63:0] ^ core_iv;
                end
            end
        end
    end

    always_ff @(posedge clk) if (!rst && core_start) start_cnt <= start_cnt + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] exp_ctrl(input bit ctx, input bit inr, input bit outr,
                                             input logic [1:0] m, input bit tri3, input bit enc);
        return {ctx, 25'b0, m, tri3, enc, inr, outr};
    endfunction

    task automatic wait_ctrl_bit(input int b);
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            bus_read(7'h20, v);
            if (v[b]) return;
        end
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [31:0] v, lo, hi;
        logic [63:0] k1, ivv, d, exp_blk;
        logic [1:0]  m;
        int          len, nblk, sc;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(7'h20, v);
        check("R1 ctrl", v, 32'h8000_0000);
        check("R1 irq", irq, 0);
        check("R1 dma", {dma_ctx_req, dma_in_req, dma_out_req}, 0);

        // R10 dma gating
        bus_write(7'h34, 32'h0000_00E0);
        check("R10 ctx req", {dma_ctx_req, dma_in_req, dma_out_req}, 3'b100);

        // R11 key/iv mapping
        bus_write(7'h00, 32'h3333_0000); bus_write(7'h04, 32'h3333_1111);
        bus_write(7'h08, 32'h2222_0000); bus_write(7'h0C, 32'h2222_1111);
        bus_write(7'h10, 32'h1111_0000); bus_write(7'h14, 32'h1111_1111);
        bus_write(7'h18, 32'hAAAA_0000); bus_write(7'h1C, 32'hAAAA_1111);
        check("R11 key", core_key, {64'h3333_1111_3333_0000, 64'h2222_1111_2222_0000,
                                    64'h1111_1111_1111_0000});
        check("R11 iv", core_iv, 64'hAAAA_1111_AAAA_0000);
        bus_read(7'h14, v);
        check("R11 key read zero", v, 0);
        k1 = 64'h1111_1111_1111_0000; ivv = 64'hAAAA_1111_AAAA_0000;

        // R2 control fields and reserved mode
        bus_write(7'h20, 32'h0000_001C);
        bus_read(7'h20, v);
        check("R2 ctrl", v, exp_ctrl(1, 0, 0, 2'd1, 1, 1));
        check("R2 core fields", {core_mode, core_triple, core_encrypt}, {2'd1, 1'b1, 1'b1});
        bus_write(7'h20, 32'h0000_0030);
        bus_read(7'h20, v);
        check("R2 reserved mode kept", v, exp_ctrl(1, 0, 0, 2'd1, 0, 0));

        // R4 zero length starts nothing, then length 20
        bus_write(7'h24, 0);
        bus_read(7'h20, v);
        check("R4 zero len", v, exp_ctrl(1, 0, 0, 2'd1, 0, 0));
        bus_write(7'h24, 20);
        bus_read(7'h20, v);
        check("R4 started", v, exp_ctrl(0, 1, 0, 2'd1, 0, 0));
        bus_read(7'h24, v);
        check("R4 len reads zero", v, 0);
        check("R10 in req", {dma_ctx_req, dma_in_req, dma_out_req}, 3'b010);

        // R3 locked context
        bus_write(7'h10, 32'hDEAD_BEEF);
        bus_write(7'h20, 32'h0000_002C);
        check("R3 key locked", core_key[63:0], k1);
        check("R3 ctrl locked", {core_mode, core_triple, core_encrypt}, {2'd1, 1'b0, 1'b0});

        // R5 block 1 plus a stray upper write
        sc = start_cnt;
        bus_write(7'h28, 32'h0102_0304);
        bus_write(7'h2C, 32'h0506_0708);
        bus_write(7'h2C, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R5 one start", start_cnt - sc, 1);
        wait_ctrl_bit(0);
        repeat (LAT + 2) @(negedge clk);
        check("R5 no extra start", start_cnt - sc, 1);
        exp_blk = 64'h0506_0708_0102_0304 ^ k1 ^ ivv;
        bus_read(7'h20, v);
        check("R6 out ready", v, exp_ctrl(0, 0, 1, 2'd1, 0, 0));
        bus_read(7'h3C, v);
        check("R8 status in+out", v, 32'h6);
        check("R9 masked", irq, 0);
        bus_write(7'h40, 32'h4);
        check("R9 enabled", irq, 1);
        bus_write(7'h3C, 32'h4);
        bus_read(7'h3C, v);
        check("R8 w1c", v, 32'h2);
        check("R9 cleared", irq, 0);
        bus_read(7'h28, lo);
        bus_read(7'h2C, hi);
        check("R6 result", {hi, lo}, exp_blk);
        bus_read(7'h20, v);
        check("R7 more input", v, exp_ctrl(0, 1, 0, 2'd1, 0, 0));

        // blocks 2 and 3 (12 then 4 bytes left; last saturates)
        for (int b = 0; b < 2; b++) begin
            d = {$urandom, $urandom};
            bus_write(7'h28, d[31:0]);
            bus_write(7'h2C, d[63:32]);
            wait_ctrl_bit(0);
            bus_read(7'h28, lo);
            bus_read(7'h2C, hi);
            check("R6 result", {hi, lo}, d ^ k1 ^ ivv);
        end
        bus_read(7'h20, v);
        check("R7 ctx back after 3 blocks", v, exp_ctrl(1, 0, 0, 2'd1, 0, 0));
        bus_read(7'h3C, v);
        check("R8 ctx event", v[0], 1);
        check("R10 ctx req again", {dma_ctx_req, dma_in_req, dma_out_req}, 3'b100);
        bus_write(7'h3C, 32'h7);
        bus_read(7'h3C, v);
        check("R8 all cleared", v, 0);

        // random jobs
        for (int run = 0; run < 30; run++) begin
            k1  = {$urandom, $urandom};
            ivv = {$urandom, $urandom};
            m   = 2'($urandom % 3);
            bus_write(7'h10, k1[31:0]);  bus_write(7'h14, k1[63:32]);
            bus_write(7'h18, ivv[31:0]); bus_write(7'h1C, ivv[63:32]);
            bus_write(7'h20, {26'b0, m, 4'b1100});
            check("R2 random mode", core_mode, m);
            len  = 1 + int'($urandom % 40);
            nblk = (len + 7) / 8;
            bus_write(7'h24, len);
            for (int b = 0; b < nblk; b++) begin
                bus_read(7'h20, v);
                check("R7 input open", v[1], 1);
                d = {$urandom, $urandom};
                bus_write(7'h28, d[31:0]);
                bus_write(7'h2C, d[63:32]);
                wait_ctrl_bit(0);
                bus_read(7'h28, lo);
                bus_read(7'h2C, hi);
                check("R6 random result", {hi, lo}, d ^ k1 ^ ivv);
            end
            bus_read(7'h20, v);
            check("R7 job end", v, exp_ctrl(1, 0, 0, m, 1, 1));
        end

        report();
    end

endmodule